// File: doc/BRIEF.md
# Boost Converter Switch Controller with Protection Latches

This block is the digital half of a fixed-frequency boost converter that feeds two constant-current LED strings. Once per switching period it turns the power switch gate on at the start of the period and holds it for a commanded number of clock ticks. The on-time is clamped so that every period keeps a minimum off-time. When the peak-current comparator trips, the gate stays off until the next period begins.

The block also watches the protection comparators. Undervoltage and overtemperature hold the gate off only while they are asserted, and switching resumes by itself once they clear. An open LED string shows up as the output overvoltage comparator set together with a starved LED sink. If that combination is seen at eight period boundaries in a row, a fault is latched and switching stops. The latch clears only when the converter enable is taken low and raised again.

The analog comparators and the loop compensation are outside the block. Each arrives as a synchronous digital input, and the duty command is a plain tick count.

Top module: `boost_ctrl`

## Requirements
- R1: While en_i is low, gate_o and open_fault_o are both low; this is also the state right after reset.
- R2: With en_i high, the switching period is PERIOD = CLK_HZ / SW_HZ clock ticks (166 at the defaults), and the gate rises once per period, at its first tick.
- R3: In each period the gate is high for exactly duty_i ticks, counted from the first tick of the period. A new duty_i value takes effect from the next period.
- R4: The on-time is clamped to PERIOD - MIN_OFF_TICKS ticks (158 at the defaults). Any larger duty_i gives that on-time.
- R5: A high ilim_i sampled at a clock edge forces gate_o low from that edge to the end of the period. The following period runs its full on-time.
- R6: The open-LED condition is ovp_i high together with at least one bit of sink_low_i high. It is sampled at the last tick of each period. When the condition is present at OPEN_CYCLES (8) consecutive period boundaries, open_fault_o goes high and gate_o stays low. ovp_i alone, or sink_low_i alone, never raises the fault.
- R7: A period boundary without the open-LED condition restarts the consecutive count. Seven boundaries in a row do not raise the fault.
- R8: Once raised, open_fault_o stays high while en_i stays high, even after the condition clears. A low en_i clears it, and switching resumes once en_i is high again.
- R9: While uvlo_i is high, gate_o is low. Switching resumes with no fault once uvlo_i clears.
- R10: While otp_i is high, gate_o is low. Switching resumes with no fault once otp_i clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Converter enable; low is shutdown and clears the fault latch |
| duty_i | input | DUTY_W (8) | Commanded on-time in clock ticks |
| ilim_i | input | 1 | Peak switch current comparator, high = over limit |
| ovp_i | input | 1 | Output overvoltage comparator, high = over threshold |
| sink_low_i | input | SINKS (2) | Per-sink low-voltage comparator, high = sink starved |
| uvlo_i | input | 1 | Supply undervoltage flag |
| otp_i | input | 1 | Overtemperature flag |
| gate_o | output | 1 | Power switch gate drive |
| open_fault_o | output | 1 | Latched open-LED fault |

## Verification
The assertions assume that every comparator input is synchronous to clk_i and changes only between clock edges. They also assume that en_i is the only way to leave a latched fault. The bench drives every input on the falling clock edge and samples the outputs there, so each input is stable for a whole tick around the rising edge. The fault windows are sized in whole periods, which makes the number of period boundaries seen under a held condition exact, whatever phase the period is in.

// File: rtl/boost_pkg.sv
package boost_pkg;

    // Why the gate is allowed or held off.
    typedef enum logic [1:0] {
        DRV_OFF  = 2'd0,   // converter disabled
        DRV_HOLD = 2'd1,   // inhibited by a protection input or latched fault
        DRV_RUN  = 2'd2    // switching permitted
    } drive_mode_e;

    // Saturate a requested tick count to a limit.
    function automatic int unsigned clamp_ticks(int unsigned req, int unsigned lim);
        return (req > lim) ? lim : req;
    endfunction

endpackage

// File: rtl/boost_period_timer.sv
module boost_period_timer #(
    parameter int PERIOD = 166,
    localparam int CW    = $clog2(PERIOD)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          run_i,
    output logic [CW-1:0] cnt_o,
    output logic          wrap_o
);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic last_tick;

    always_comb begin
        tmr_d     = tmr_q;
        last_tick = (tmr_q.cnt == CW'(PERIOD - 1));
        if (!run_i || last_tick) begin
            tmr_d.cnt = '0;
        end else begin
            tmr_d.cnt = tmr_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) tmr_q <= '0;
        else         tmr_q <= tmr_d;
    end

    assign cnt_o  = tmr_q.cnt;
    assign wrap_o = run_i && last_tick;

endmodule

// File: rtl/boost_pulse_gen.sv
module boost_pulse_gen #(
    parameter int PERIOD  = 166,
    parameter int MIN_OFF = 8,
    parameter int DUTY_W  = 8,
    localparam int CW     = $clog2(PERIOD),
    localparam int MAX_ON = PERIOD - MIN_OFF
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    input  logic              allow_i,
    input  logic [CW-1:0]     cnt_i,
    input  logic              wrap_i,
    input  logic [DUTY_W-1:0] duty_i,
    input  logic              ilim_i,
    output logic              gate_o
);

    typedef struct packed {
        logic [CW-1:0] on_ticks;  // on-time for the running period
        logic          cut;       // current limit hit in this period
    } pg_t;

    pg_t pg_d, pg_q;
    logic [CW-1:0] clamped;

    always_comb begin
        pg_d    = pg_q;
        clamped = CW'(boost_pkg::clamp_ticks(32'(duty_i), MAX_ON));
        // load the on-time for the next period at its boundary
        if (!en_i || wrap_i) begin
            pg_d.on_ticks = clamped;
        end
        // the cut lasts for the rest of the period only
        if (!en_i || wrap_i) begin
            pg_d.cut = 1'b0;
        end else if (ilim_i) begin
            pg_d.cut = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pg_q <= '0;
        else         pg_q <= pg_d;
    end

    assign gate_o = allow_i && !pg_q.cut && (cnt_i < pg_q.on_ticks);

endmodule

// File: rtl/boost_open_led.sv
module boost_open_led #(
    parameter int SINKS       = 2,
    parameter int OPEN_CYCLES = 8,
    localparam int NW         = $clog2(OPEN_CYCLES + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic             wrap_i,
    input  logic             ovp_i,
    input  logic [SINKS-1:0] sink_low_i,
    output logic             fault_o
);

    typedef struct packed {
        logic [NW-1:0] run_len;  // consecutive boundaries with the condition
        logic          fault;
    } ol_t;

    ol_t ol_d, ol_q;
    logic any_low;
    logic cond;

    // any starved sink counts; a single sink needs no reduction
    generate
        if (SINKS == 1) begin : g_one
            assign any_low = sink_low_i[0];
        end else begin : g_many
            assign any_low = |sink_low_i;
        end
    endgenerate

    assign cond = ovp_i && any_low;

    always_comb begin
        ol_d = ol_q;
        if (!en_i) begin
            ol_d = '0;
        end else if (wrap_i) begin
            if (cond) begin
                if (ol_q.run_len == NW'(OPEN_CYCLES - 1)) begin
                    ol_d.fault = 1'b1;
                end
                if (ol_q.run_len != NW'(OPEN_CYCLES)) begin
                    ol_d.run_len = ol_q.run_len + NW'(1);
                end
            end else begin
                ol_d.run_len = '0;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ol_q <= '0;
        else         ol_q <= ol_d;
    end

    assign fault_o = ol_q.fault;

endmodule

// File: rtl/boost_ctrl.sv
module boost_ctrl #(
    parameter int CLK_HZ        = 100_000_000,
    parameter int SW_HZ         = 600_000,
    parameter int MIN_OFF_TICKS = 8,
    parameter int DUTY_W        = 8,
    parameter int SINKS         = 2,
    parameter int OPEN_CYCLES   = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    input  logic [DUTY_W-1:0] duty_i,
    input  logic              ilim_i,
    input  logic              ovp_i,
    input  logic [SINKS-1:0]  sink_low_i,
    input  logic              uvlo_i,
    input  logic              otp_i,
    output logic              gate_o,
    output logic              open_fault_o
);

    import boost_pkg::*;

    localparam int PERIOD = CLK_HZ / SW_HZ;
    localparam int CW     = $clog2(PERIOD);
    localparam int MAX_ON = PERIOD - MIN_OFF_TICKS;

    logic [CW-1:0] cnt_w;
    logic          wrap_w;
    logic          fault_w;
    drive_mode_e   mode;
    logic          allow;

    always_comb begin
        if (!en_i)                          mode = DRV_OFF;
        else if (uvlo_i || otp_i || fault_w) mode = DRV_HOLD;
        else                                mode = DRV_RUN;
    end

    assign allow = (mode == DRV_RUN);

    boost_period_timer #(.PERIOD(PERIOD)) u_timer (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (en_i),
        .cnt_o  (cnt_w),
        .wrap_o (wrap_w)
    );

    boost_pulse_gen #(
        .PERIOD  (PERIOD),
        .MIN_OFF (MIN_OFF_TICKS),
        .DUTY_W  (DUTY_W)
    ) u_pulse (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .en_i    (en_i),
        .allow_i (allow),
        .cnt_i   (cnt_w),
        .wrap_i  (wrap_w),
        .duty_i  (duty_i),
        .ilim_i  (ilim_i),
        .gate_o  (gate_o)
    );

    boost_open_led #(
        .SINKS       (SINKS),
        .OPEN_CYCLES (OPEN_CYCLES)
    ) u_open (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .en_i       (en_i),
        .wrap_i     (wrap_w),
        .ovp_i      (ovp_i),
        .sink_low_i (sink_low_i),
        .fault_o    (fault_w)
    );

    assign open_fault_o = fault_w;

endmodule

// File: rtl/boost_ctrl_chk.sv
module boost_ctrl_chk #(
    parameter int CW     = 8,
    parameter int MAX_ON = 158
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en,
    input logic          ilim,
    input logic          uvlo,
    input logic          otp,
    input logic          gate,
    input logic          fault,
    input logic [CW-1:0] cnt,
    input logic          wrap
);

    // R1 / R8: shutdown clears the latch
    p_shutdown_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !fault);

    // R2: a boundary starts a new period at tick zero
    p_wrap_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt == '0));

    // R4: the gate is never on past the clamp
    p_clamp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        gate |-> (cnt < CW'(MAX_ON)));

    // R5: current limit inside a period keeps the gate off afterwards
    p_cut_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ilim && !wrap) |=> !gate);

    // R6: a latched fault blocks the gate
    p_fault_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> !gate);

    // R8: the latch holds while enabled
    p_fault_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && en) |=> fault);

    // R9: undervoltage inhibits switching
    p_uvlo_r9: assert property (@(posedge clk) disable iff (!rst_n)
        uvlo |-> !gate);

    // R10: overtemperature inhibits switching
    p_otp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        otp |-> !gate);

endmodule

bind boost_ctrl boost_ctrl_chk #(.CW(CW), .MAX_ON(MAX_ON)) u_chk (
    .clk   (clk_i),
    .rst_n (rst_ni),
    .en    (en_i),
    .ilim  (ilim_i),
    .uvlo  (uvlo_i),
    .otp   (otp_i),
    .gate  (gate_o),
    .fault (open_fault_o),
    .cnt   (cnt_w),
    .wrap  (wrap_w)
);

// File: tb/tb_boost_ctrl.sv
`timescale 1ns/1ps
module tb_boost_ctrl;

    localparam int P      = 166;
    localparam int MAX_ON = 158;
    localparam int NV     = 6;
    // duty command, expected high ticks per period (R3, R4)
    localparam int VEC [NV][2] = '{
        '{0, 0}, '{1, 1}, '{50, 50}, '{158, 158}, '{159, 158}, '{255, 158}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [7:0] duty = '0;
    logic       ilim = 1'b0;
    logic       ovp = 1'b0;
    logic [1:0] sink_low = '0;
    logic       uvlo = 1'b0;
    logic       otp = 1'b0;
    logic       gate;
    logic       fault;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    boost_ctrl dut (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .en_i         (en),
        .duty_i       (duty),
        .ilim_i       (ilim),
        .ovp_i        (ovp),
        .sink_low_i   (sink_low),
        .uvlo_i       (uvlo),
        .otp_i        (otp),
        .gate_o       (gate),
        .open_fault_o (fault)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // gate-high samples over n ticks
    task automatic count_high(input int n, output int hi);
        hi = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (gate) hi++;
        end
    endtask

    // wait until a sampled rising edge of the gate
    task automatic find_rise();
        logic prev;
        prev = gate;
        for (int i = 0; i < 4 * P; i++) begin
            @(negedge clk);
            if (gate && !prev) return;
            prev = gate;
        end
    endtask

    // hold the open-LED inputs for n ticks, then release
    task automatic hold_cond(input logic o, input logic [1:0] s, input int n);
        ovp = o;
        sink_low = s;
        ticks(n);
        ovp = 1'b0;
        sink_low = '0;
    endtask

    initial begin
        int hi;
        int gap;
        // reset state (R1)
        ticks(3);
        check("R1 gate in reset", int'(gate), 0);
        check("R1 fault in reset", int'(fault), 0);
        rst_n = 1'b1;
        duty = 8'd50;
        ticks(3);
        count_high(P, hi);
        check("R1 gate while disabled", hi, 0);
        en = 1'b1;

        // table walk (R3, R4)
        for (int v = 0; v < NV; v++) begin
            duty = 8'(VEC[v][0]);
            ticks(2 * P);
            count_high(P, hi);
            check("R3/R4 on-time per period", hi, VEC[v][1]);
        end

        // period length (R2)
        duty = 8'd50;
        ticks(2 * P);
        find_rise();
        gap = 0;
        begin
            logic prev;
            prev = 1'b1;
            for (int i = 0; i < 2 * P; i++) begin
                @(negedge clk);
                gap++;
                if (gate && !prev) break;
                prev = gate;
            end
        end
        check("R2 rise-to-rise ticks", gap, P);

        // current-limit truncation (R5)
        duty = 8'd100;
        ticks(2 * P);
        find_rise();
        hi = 1;
        for (int i = 0; i < 19; i++) begin
            @(negedge clk);
            if (gate) hi++;
        end
        ilim = 1'b1;
        @(negedge clk);
        ilim = 1'b0;
        for (int i = 0; i < P - 21; i++) begin
            @(negedge clk);
            if (gate) hi++;
        end
        check("R5 truncated on-time", hi, 20);
        ticks(P);
        count_high(P, hi);
        check("R5 next period full", hi, 100);

        // open-LED detection (R6, R7)
        duty = 8'd50;
        ticks(2 * P);
        hold_cond(1'b1, 2'b01, 7 * P);
        ticks(3);
        check("R7 seven boundaries no fault", int'(fault), 0);
        ticks(P);
        hold_cond(1'b1, 2'b10, 5 * P);
        ticks(P);
        hold_cond(1'b1, 2'b01, 5 * P);
        ticks(3);
        check("R7 broken run restarts count", int'(fault), 0);
        ticks(P);
        hold_cond(1'b1, 2'b00, 9 * P);
        ticks(3);
        check("R6 ovp alone no fault", int'(fault), 0);
        hold_cond(1'b0, 2'b11, 9 * P);
        ticks(3);
        check("R6 sink low alone no fault", int'(fault), 0);
        ticks(P);
        hold_cond(1'b1, 2'b10, 8 * P);
        ticks(3);
        check("R6 fault after eight boundaries", int'(fault), 1);
        count_high(P, hi);
        check("R6 gate off under fault", hi, 0);
        ticks(2 * P);
        check("R8 fault holds after condition clears", int'(fault), 1);

        // shutdown and restart (R8, R1)
        en = 1'b0;
        ticks(3);
        check("R8 fault cleared by shutdown", int'(fault), 0);
        check("R1 gate low when disabled", int'(gate), 0);
        en = 1'b1;
        ticks(2 * P);
        count_high(P, hi);
        check("R8 switching resumes after restart", hi, 50);

        // undervoltage (R9)
        uvlo = 1'b1;
        ticks(2);
        count_high(P, hi);
        check("R9 gate held by uvlo", hi, 0);
        uvlo = 1'b0;
        ticks(2 * P);
        count_high(P, hi);
        check("R9 auto resume", hi, 50);
        check("R9 no latched fault", int'(fault), 0);

        // overtemperature (R10)
        otp = 1'b1;
        ticks(2);
        count_high(P, hi);
        check("R10 gate held by otp", hi, 0);
        otp = 1'b0;
        ticks(2 * P);
        count_high(P, hi);
        check("R10 auto resume", hi, 50);
        check("R10 no latched fault", int'(fault), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule